// File: doc/BRIEF.md
# Vector Operand Register File with Swizzle and Negate

This block is the operand-fetch and writeback stage of a small programmable vertex processor. It holds four banks of four-lane vectors: read-only vertex inputs, program constants, read/write temporaries and write-only vertex outputs. Each lane is an opaque 32-bit word whose bit 31 is the sign. In one cycle the block reads up to three source vectors. Each source gets its own lane swizzle and an optional sign flip. The block also writes one result vector under a per-lane mask.

Source reads are purely combinational, so swizzle and negate add no cycle. Writes land on the next rising edge. A host port fills the input bank at any time. The same port fills the constant bank, but only while no vertex is in flight. A drain port reads the output bank so the finished vertex can leave the block. Illegal datapath accesses are refused and reported on an error flag in the same cycle.

Top module: `vec_operand_rf`

## Requirements
- R1: After reset, every register of every bank reads as all-zero.
- R2: Each source swizzle is four 2-bit selectors, with bits [2l+1:2l] choosing the source for output lane l (lane 0 = x at data bits [31:0], up to lane 3 = w at bits [127:96]). The codes are 00 = x, 01 = y, 10 = z, 11 = w, and repeats are allowed.
- R3: When a source's negate bit is 1, bit 31 of each of its four lanes is inverted after the swizzle. No other bit changes.
- R4: All three sources are fetched independently and combinationally in the same cycle, each with its own bank, index, swizzle and negate.
- R5: A destination write updates only the lanes whose mask bit is 1 (mask bit l = lane l). The other lanes keep their old value, and the new value is visible from the cycle after the edge.
- R6: A register selector is a 2-bit bank code (00 input, 01 constant, 10 temporary, 11 output) plus a 7-bit index. The bank sizes are 16, 96, 12 and 15. An enabled source that names the output bank or an out-of-range index reads as a zero vector (still swizzled and negated) and raises the error flag in that cycle.
- R7: A datapath write that names the input bank, the constant bank or an out-of-range index changes no register and raises the error flag in that cycle.
- R8: A host write with bank bit 1 stores a full vector into the constant bank only while busy is 0. When busy is 1 it is ignored.
- R9: A host write with bank bit 0 stores a full vector into the input bank regardless of busy.
- R10: When a temporary is written and read in the same cycle, the read returns the old value. There is no bypass.
- R11: The drain port returns the output register chosen by its index, or zero for index 15.
- R12: The error flag is 0 in any cycle where no enabled source and no datapath write is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | A vertex is being processed; blocks constant loads |
| hostWrEn | input | 1 | Host write strobe |
| hostBank | input | 1 | 0 = input bank, 1 = constant bank |
| hostIdx | input | 7 | Host write index |
| hostData | input | 128 | Host write vector |
| srcEn | input | 3 | Per-source read enable (error reporting only) |
| srcBank | input | 3x2 | Per-source bank code |
| srcIdx | input | 3x7 | Per-source register index |
| srcSwz | input | 3x8 | Per-source swizzle code |
| srcNeg | input | 3 | Per-source negate |
| srcOperand | output | 3x128 | Swizzled, negated source vectors |
| dstWrEn | input | 1 | Datapath write strobe |
| dstBank | input | 2 | Destination bank code |
| dstIdx | input | 7 | Destination index |
| dstMask | input | 4 | Per-lane write mask |
| dstData | input | 128 | Result vector |
| drainIdx | input | 4 | Output-bank drain index |
| drainData | output | 128 | Drained output vector |
| accessErr | output | 1 | Illegal datapath access this cycle |

## Verification
A masked write to a temporary and a read of that same temporary can fall in the same cycle. So can a host constant load and a busy vertex. The random stimulus draws temporary indices from a small range so that writes and reads collide often. It also toggles busy at random under host traffic. Directed cycles force both collisions. Each collision is judged against a bench model that applies writes only after the edge, so a same-cycle read must return the pre-write vector. A busy constant load must leave the old constant readable in the next cycle.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int LANES = 4;
  localparam int LANE_W = 32;
  localparam int VEC_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    BANK_IN  = 2'd0,
    BANK_CST = 2'd1,
    BANK_TMP = 2'd2,
    BANK_OUT = 2'd3
  } bank_e;

  typedef struct packed {
    logic             hostInWe;
    logic             hostCstWe;
    logic             tmpWe;
    logic             outWe;
    logic [LANES-1:0] laneMask;
  } wrStrobe_t;
endpackage

// File: rtl/vrf_ctrl.sv
module vrf_ctrl
  import vrf_pkg::*;
#(
  parameter int NUM_IN  = 16,
  parameter int NUM_CST = 96,
  parameter int NUM_TMP = 12,
  parameter int NUM_OUT = 15,
  parameter int NUM_SRC = 3,
  parameter int IDX_W   = 7
) (
  input  logic                            busy,
  input  logic                            hostWrEn,
  input  logic                            hostBank,
  input  logic [IDX_W-1:0]                hostIdx,
  input  logic [NUM_SRC-1:0]              srcEn,
  input  logic [NUM_SRC-1:0][1:0]         srcBank,
  input  logic [NUM_SRC-1:0][IDX_W-1:0]   srcIdx,
  input  logic                            dstWrEn,
  input  logic [1:0]                      dstBank,
  input  logic [IDX_W-1:0]                dstIdx,
  input  logic [LANES-1:0]                dstMask,
  output wrStrobe_t                       strb,
  output logic [NUM_SRC-1:0]              rdOk,
  output logic                            accessErr
);
  localparam logic [IDX_W-1:0] IN_LIM  = IDX_W'(NUM_IN);
  localparam logic [IDX_W-1:0] CST_LIM = IDX_W'(NUM_CST);
  localparam logic [IDX_W-1:0] TMP_LIM = IDX_W'(NUM_TMP);
  localparam logic [IDX_W-1:0] OUT_LIM = IDX_W'(NUM_OUT);

  logic tmpDst, outDst;

  always_comb begin
    for (int k = 0; k < NUM_SRC; k++) begin
      unique case (srcBank[k])
        BANK_IN:  rdOk[k] = srcIdx[k] < IN_LIM;
        BANK_CST: rdOk[k] = srcIdx[k] < CST_LIM;
        BANK_TMP: rdOk[k] = srcIdx[k] < TMP_LIM;
        default:  rdOk[k] = 1'b0;
      endcase
    end
    tmpDst = dstBank == BANK_TMP && dstIdx < TMP_LIM;
    outDst = dstBank == BANK_OUT && dstIdx < OUT_LIM;
    strb.tmpWe     = dstWrEn && tmpDst;
    strb.outWe     = dstWrEn && outDst;
    strb.laneMask  = dstMask;
    strb.hostInWe  = hostWrEn && !hostBank && hostIdx < IN_LIM;
    strb.hostCstWe = hostWrEn && hostBank && !busy && hostIdx < CST_LIM;
    accessErr = (|(srcEn & ~rdOk)) || (dstWrEn && !(tmpDst || outDst));
  end
endmodule

// File: rtl/vrf_datapath.sv
module vrf_datapath
  import vrf_pkg::*;
#(
  parameter int NUM_IN  = 16,
  parameter int NUM_CST = 96,
  parameter int NUM_TMP = 12,
  parameter int NUM_OUT = 15,
  parameter int NUM_SRC = 3,
  parameter int IDX_W   = 7,
  parameter int DRAIN_W = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  wrStrobe_t                       strb,
  input  logic [IDX_W-1:0]                hostIdx,
  input  logic [VEC_W-1:0]                hostData,
  input  logic [IDX_W-1:0]                dstIdx,
  input  logic [VEC_W-1:0]                dstData,
  input  logic [NUM_SRC-1:0][1:0]         srcBank,
  input  logic [NUM_SRC-1:0][IDX_W-1:0]   srcIdx,
  input  logic [NUM_SRC-1:0][2*LANES-1:0] srcSwz,
  input  logic [NUM_SRC-1:0]              srcNeg,
  input  logic [NUM_SRC-1:0]              rdOk,
  input  logic [DRAIN_W-1:0]              drainIdx,
  output logic [NUM_SRC-1:0][VEC_W-1:0]   srcOperand,
  output logic [VEC_W-1:0]                drainData
);
  logic [NUM_IN-1:0][VEC_W-1:0]  inMem;
  logic [NUM_CST-1:0][VEC_W-1:0] cstMem;
  logic [NUM_TMP-1:0][VEC_W-1:0] tmpMem;
  logic [NUM_OUT-1:0][VEC_W-1:0] outMem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inMem  <= '0;
      cstMem <= '0;
      tmpMem <= '0;
      outMem <= '0;
    end else begin
      for (int e = 0; e < NUM_IN; e++)
        if (strb.hostInWe && hostIdx == IDX_W'(e)) inMem[e] <= hostData;
      for (int e = 0; e < NUM_CST; e++)
        if (strb.hostCstWe && hostIdx == IDX_W'(e)) cstMem[e] <= hostData;
      for (int e = 0; e < NUM_TMP; e++)
        for (int l = 0; l < LANES; l++)
          if (strb.tmpWe && strb.laneMask[l] && dstIdx == IDX_W'(e))
            tmpMem[e][l*LANE_W +: LANE_W] <= dstData[l*LANE_W +: LANE_W];
      for (int e = 0; e < NUM_OUT; e++)
        for (int l = 0; l < LANES; l++)
          if (strb.outWe && strb.laneMask[l] && dstIdx == IDX_W'(e))
            outMem[e][l*LANE_W +: LANE_W] <= dstData[l*LANE_W +: LANE_W];
    end
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic [VEC_W-1:0] raw, opnd;
    always_comb begin
      raw = '0;
      if (rdOk[k]) begin
        for (int e = 0; e < NUM_IN; e++)
          if (srcBank[k] == BANK_IN && srcIdx[k] == IDX_W'(e)) raw = inMem[e];
        for (int e = 0; e < NUM_CST; e++)
          if (srcBank[k] == BANK_CST && srcIdx[k] == IDX_W'(e)) raw = cstMem[e];
        for (int e = 0; e < NUM_TMP; e++)
          if (srcBank[k] == BANK_TMP && srcIdx[k] == IDX_W'(e)) raw = tmpMem[e];
      end
      opnd = '0;
      for (int l = 0; l < LANES; l++) begin
        for (int c = 0; c < LANES; c++)
          if (srcSwz[k][2*l +: 2] == 2'(c))
            opnd[l*LANE_W +: LANE_W] = raw[c*LANE_W +: LANE_W];
        opnd[l*LANE_W + LANE_W - 1] = opnd[l*LANE_W + LANE_W - 1] ^ srcNeg[k];
      end
    end
    assign srcOperand[k] = opnd;
  end

  always_comb begin
    drainData = '0;
    for (int e = 0; e < NUM_OUT; e++)
      if (drainIdx == DRAIN_W'(e)) drainData = outMem[e];
  end

  // R8
  cst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.hostCstWe |=> $stable(cstMem));
  // R7
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.hostInWe |=> $stable(inMem));
endmodule

// File: rtl/vec_operand_rf.sv
module vec_operand_rf
  import vrf_pkg::*;
#(
  parameter int NUM_IN  = 16,
  parameter int NUM_CST = 96,
  parameter int NUM_TMP = 12,
  parameter int NUM_OUT = 15,
  parameter int NUM_SRC = 3,
  parameter int IDX_W   = 7,
  parameter int DRAIN_W = $clog2(NUM_OUT + 1)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  busy,
  input  logic                                  hostWrEn,
  input  logic                                  hostBank,
  input  logic [IDX_W-1:0]                      hostIdx,
  input  logic [4*32-1:0]                       hostData,
  input  logic [NUM_SRC-1:0]                    srcEn,
  input  logic [NUM_SRC-1:0][1:0]               srcBank,
  input  logic [NUM_SRC-1:0][IDX_W-1:0]         srcIdx,
  input  logic [NUM_SRC-1:0][7:0]               srcSwz,
  input  logic [NUM_SRC-1:0]                    srcNeg,
  output logic [NUM_SRC-1:0][4*32-1:0]          srcOperand,
  input  logic                                  dstWrEn,
  input  logic [1:0]                            dstBank,
  input  logic [IDX_W-1:0]                      dstIdx,
  input  logic [3:0]                            dstMask,
  input  logic [4*32-1:0]                       dstData,
  input  logic [DRAIN_W-1:0]                    drainIdx,
  output logic [4*32-1:0]                       drainData,
  output logic                                  accessErr
);
  wrStrobe_t strb;
  logic [NUM_SRC-1:0] rdOk;

  vrf_ctrl #(.NUM_IN(NUM_IN), .NUM_CST(NUM_CST), .NUM_TMP(NUM_TMP),
             .NUM_OUT(NUM_OUT), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_ctrl (
    .busy(busy), .hostWrEn(hostWrEn), .hostBank(hostBank), .hostIdx(hostIdx),
    .srcEn(srcEn), .srcBank(srcBank), .srcIdx(srcIdx),
    .dstWrEn(dstWrEn), .dstBank(dstBank), .dstIdx(dstIdx), .dstMask(dstMask),
    .strb(strb), .rdOk(rdOk), .accessErr(accessErr));

  vrf_datapath #(.NUM_IN(NUM_IN), .NUM_CST(NUM_CST), .NUM_TMP(NUM_TMP),
                 .NUM_OUT(NUM_OUT), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W),
                 .DRAIN_W(DRAIN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .hostIdx(hostIdx), .hostData(hostData),
    .dstIdx(dstIdx), .dstData(dstData), .srcBank(srcBank), .srcIdx(srcIdx),
    .srcSwz(srcSwz), .srcNeg(srcNeg), .rdOk(rdOk), .drainIdx(drainIdx),
    .srcOperand(srcOperand), .drainData(drainData));

  // R6
  out_read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srcEn[0] && srcBank[0] == BANK_OUT) |-> accessErr);
  // R3
  negate_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srcBank[0] == srcBank[1] && srcIdx[0] == srcIdx[1] && srcSwz[0] == srcSwz[1]
     && srcNeg[0] != srcNeg[1])
    |-> (srcOperand[0] ^ srcOperand[1]) == {4{32'h8000_0000}});
  // R2
  broadcast_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srcBank[0] == srcBank[1] && srcIdx[0] == srcIdx[1] && srcNeg[0] == srcNeg[1]
     && srcSwz[0] == 8'hE4 && srcSwz[1] == 8'h00)
    |-> srcOperand[1] == {4{srcOperand[0][31:0]}});
endmodule

// File: tb/vec_operand_rf_bench.sv
module vec_operand_rf_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, busy, hostWrEn, hostBank, dstWrEn, accessErr;
  logic [6:0] hostIdx, dstIdx;
  logic [127:0] hostData, dstData, drainData;
  logic [2:0] srcEn, srcNeg;
  logic [2:0][1:0] srcBank;
  logic [2:0][6:0] srcIdx;
  logic [2:0][7:0] srcSwz;
  logic [2:0][127:0] srcOperand;
  logic [1:0] dstBank;
  logic [3:0] dstMask, drainIdx;

  logic [127:0] mIn[16], mCst[96], mTmp[12], mOut[15];
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_operand_rf u_vec_operand_rf (.*);

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic bit legalRd(logic [1:0] b, logic [6:0] i);
    case (b)
      2'd0: return int'(i) < 16;
      2'd1: return int'(i) < 96;
      2'd2: return int'(i) < 12;
      default: return 0;
    endcase
  endfunction

  function automatic bit legalWr(logic [1:0] b, logic [6:0] i);
    return (b == 2'd2 && int'(i) < 12) || (b == 2'd3 && int'(i) < 15);
  endfunction

  function automatic logic [127:0] modelOp(logic [1:0] b, logic [6:0] i,
                                           logic [7:0] swz, logic neg);
    logic [127:0] raw = '0, r;
    if (legalRd(b, i))
      case (b)
        2'd0: raw = mIn[int'(i)];
        2'd1: raw = mCst[int'(i)];
        default: raw = mTmp[int'(i)];
      endcase
    for (int l = 0; l < 4; l++) begin
      r[l*32 +: 32] = raw[int'(swz[2*l +: 2])*32 +: 32];
      r[l*32 + 31] ^= neg;
    end
    return r;
  endfunction

  function automatic logic [127:0] mergeMask(logic [127:0] old, logic [127:0] nw,
                                             logic [3:0] m);
    for (int l = 0; l < 4; l++) if (m[l]) old[l*32 +: 32] = nw[l*32 +: 32];
    return old;
  endfunction

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    busy = 0; hostWrEn = 0; hostBank = 0; hostIdx = 0; hostData = 0;
    srcEn = 0; srcNeg = 0; srcBank = '0; srcIdx = '0; srcSwz = {3{8'hE4}};
    dstWrEn = 0; dstBank = 0; dstIdx = 0; dstMask = 0; dstData = 0; drainIdx = 0;
  endtask

  // Called just after a falling edge with inputs set; checks outputs, then
  // advances one clock and applies the writes to the model after the edge.
  task automatic cycle(string tag);
    logic [127:0] e;
    bit err = 0;
    #1;
    for (int k = 0; k < 3; k++) begin
      e = modelOp(srcBank[k], srcIdx[k], srcSwz[k], srcNeg[k]);
      chk(srcOperand[k] === e, tag, srcOperand[k], e);
      if (srcEn[k] && !legalRd(srcBank[k], srcIdx[k])) err = 1;
    end
    if (dstWrEn && !legalWr(dstBank, dstIdx)) err = 1;
    chk(accessErr === err, {tag, " err R6 R7 R12"}, 128'(accessErr), 128'(err));
    e = (drainIdx < 15) ? mOut[int'(drainIdx)] : '0;
    chk(drainData === e, {tag, " drain R11"}, drainData, e);
    @(posedge clk);
    if (hostWrEn && !hostBank && int'(hostIdx) < 16) mIn[int'(hostIdx)] = hostData;
    if (hostWrEn && hostBank && !busy && int'(hostIdx) < 96) mCst[int'(hostIdx)] = hostData;
    if (dstWrEn && dstBank == 2'd2 && int'(dstIdx) < 12)
      mTmp[int'(dstIdx)] = mergeMask(mTmp[int'(dstIdx)], dstData, dstMask);
    if (dstWrEn && dstBank == 2'd3 && int'(dstIdx) < 15)
      mOut[int'(dstIdx)] = mergeMask(mOut[int'(dstIdx)], dstData, dstMask);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    foreach (mIn[i]) mIn[i] = '0;
    foreach (mCst[i]) mCst[i] = '0;
    foreach (mTmp[i]) mTmp[i] = '0;
    foreach (mOut[i]) mOut[i] = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state across banks and the drain port
    for (int i = 0; i < 15; i++) begin
      idle(); srcBank = {2'd2, 2'd1, 2'd0}; srcIdx = {7'(i % 12), 7'(i), 7'(i)};
      drainIdx = 4'(i); cycle("R1 reset");
    end

    // R8: constant load while idle, then refused while busy
    idle(); hostWrEn = 1; hostBank = 1; hostIdx = 7'd5;
    hostData = 128'h44444444_33333333_22222222_11111111; cycle("R8 load");
    idle(); busy = 1; hostWrEn = 1; hostBank = 1; hostIdx = 7'd5;
    hostData = rnd128(); srcBank[0] = 2'd1; srcIdx[0] = 7'd5; cycle("R8 busy");
    idle(); busy = 1; srcBank[0] = 2'd1; srcIdx[0] = 7'd5; #1;
    chk(srcOperand[0] === 128'h44444444_33333333_22222222_11111111, "R8 kept",
        srcOperand[0], 128'h44444444_33333333_22222222_11111111);
    @(negedge clk);

    // R9: input load while busy
    idle(); busy = 1; hostWrEn = 1; hostBank = 0; hostIdx = 7'd15; hostData = rnd128();
    cycle("R9 load");

    // R2 R3 R4: three independent sources, literal expectations
    idle(); srcEn = 3'b111; srcBank = {3{2'd1}}; srcIdx = {3{7'd5}};
    srcSwz = {8'h00, 8'hE4, 8'h1B}; srcNeg = 3'b010; #1;
    chk(srcOperand[0] === 128'h11111111_22222222_33333333_44444444, "R2 reverse",
        srcOperand[0], 128'h11111111_22222222_33333333_44444444);
    chk(srcOperand[1] === 128'hC4444444_B3333333_A2222222_91111111, "R3 negate",
        srcOperand[1], 128'hC4444444_B3333333_A2222222_91111111);
    chk(srcOperand[2] === {4{32'h11111111}}, "R4 third source",
        srcOperand[2], {4{32'h11111111}});
    cycle("R4 fetch");

    // R5: masked temp write, then R10 same-cycle read returns old value
    idle(); dstWrEn = 1; dstBank = 2'd2; dstIdx = 7'd11; dstMask = 4'b0101;
    dstData = rnd128(); cycle("R5 write");
    idle(); srcBank[0] = 2'd2; srcIdx[0] = 7'd11; dstWrEn = 1; dstBank = 2'd2;
    dstIdx = 7'd11; dstMask = 4'b1111; dstData = rnd128(); cycle("R10 old value");
    idle(); srcBank[0] = 2'd2; srcIdx[0] = 7'd11; cycle("R10 new value");

    // R7: datapath writes to input/constant banks are refused
    idle(); dstWrEn = 1; dstBank = 2'd0; dstIdx = 7'd15; dstMask = 4'hF;
    dstData = rnd128(); cycle("R7 input bank");
    idle(); dstWrEn = 1; dstBank = 2'd1; dstIdx = 7'd5; dstMask = 4'hF;
    dstData = rnd128(); srcBank[0] = 2'd0; srcIdx[0] = 7'd15; cycle("R7 const bank");
    idle(); srcBank = {2'd1, 2'd1, 2'd0}; srcIdx = {7'd5, 7'd5, 7'd15}; cycle("R7 readback");

    // R6: output-bank and out-of-range reads; R11 drain of a written output
    idle(); dstWrEn = 1; dstBank = 2'd3; dstIdx = 7'd14; dstMask = 4'hF;
    dstData = rnd128(); cycle("R11 write");
    idle(); srcEn = 3'b011; srcBank = {2'd0, 2'd2, 2'd3}; srcIdx = {7'd0, 7'd12, 7'd14};
    srcNeg = 3'b001; drainIdx = 4'd14; cycle("R6 illegal read");
    idle(); srcEn = 3'b111; drainIdx = 4'd15; cycle("R12 clean");

    // Random traffic with frequent collisions
    for (int n = 0; n < 4000; n++) begin
      idle();
      busy = 1'($urandom); hostWrEn = 1'($urandom); hostBank = 1'($urandom);
      hostIdx = ($urandom % 4 == 0) ? 7'($urandom) : 7'($urandom % 16);
      hostData = rnd128();
      srcEn = 3'($urandom); srcNeg = 3'($urandom);
      for (int k = 0; k < 3; k++) begin
        srcBank[k] = 2'($urandom);
        srcIdx[k] = ($urandom % 8 == 0) ? 7'($urandom) : 7'($urandom % 16);
        srcSwz[k] = 8'($urandom);
      end
      dstWrEn = 1'($urandom); dstBank = 2'($urandom);
      dstIdx = ($urandom % 8 == 0) ? 7'($urandom) : 7'($urandom % 16);
      dstMask = 4'($urandom); dstData = rnd128(); drainIdx = 4'($urandom);
      cycle("random R2 R3 R4 R5 R10");
    end

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule